// File: doc/BRIEF.md
# BCD Time-of-Day Counter with Field Calibration

This block keeps the time of day as six packed BCD digits, two each for hours, minutes and seconds, over a 24-hour cycle from 00:00:00 to 23:59:59. It runs entirely in the system clock domain. It advances once per cycle in which the one-cycle `sec_tick` enable is high, and `sec_tick` is expected once per second. Each field overflows into the next through a carry strobe. These strobes are also outputs, so that neighbouring logic can act on minute and hour boundaries.

Two level inputs set the clock. While `cal_min` is high, the minutes field steps once per `cal_tick` pulse, which is expected at about 2 Hz. While `cal_hr` is high, the hours field steps in the same way. A field under calibration wraps within its own range and passes no carry onward. The other fields keep counting from `sec_tick` as usual. The seconds field has no way to be set. The calibration levels are assumed to be already debounced and synchronous to `clk`.

Top module: `tod_counter`

## Requirements
- R1: A low `rst_n` sampled at a rising clock edge clears all six digits to 0 at that edge (synchronous, active low).
- R2: The seconds field counts 00..59 in BCD (ones 0..9, tens 0..5), steps only at edges where `sec_tick` is high, and goes from 59 to 00.
- R3: `sec_carry` is high exactly while `sec_tick` is high and the seconds read 59. The minutes field takes that step at the same edge that clears the seconds.
- R4: The minutes field counts 00..59 in BCD. When `cal_min` is low it steps only on `sec_carry`. `min_carry` is high exactly while `sec_carry` is high, the minutes read 59 and `cal_min` is low.
- R5: The hours field counts 00..23 in BCD. It clears both digits together when it would pass 23 (tens 2, ones 3 stepping to 2/4), so that 23 goes to 00. When `cal_hr` is low it steps only on `min_carry`.
- R6: While `cal_min` is high, the minutes step once per `cal_tick` and go from 59 to 00 with no `min_carry`. `sec_carry` does not move the minutes. The seconds and hours continue as in R2 and R5.
- R7: While `cal_hr` is high, the hours step once per `cal_tick` and go from 23 to 00. `min_carry` does not move the hours. The seconds and minutes continue as in R2 to R4.
- R8: With `cal_min` and `cal_hr` both low, `cal_tick` changes no digit.
- R9: One second tick at 23:59:59 with no calibration active gives 00:00:00, with both carry strobes high in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| sec_tick | input | 1 | One-cycle enable, once per second |
| cal_tick | input | 1 | One-cycle enable at the calibration stepping rate |
| cal_min | input | 1 | Level: calibrate minutes |
| cal_hr | input | 1 | Level: calibrate hours |
| sec_ones | output | 4 | Seconds units digit, BCD |
| sec_tens | output | 4 | Seconds tens digit, BCD |
| min_ones | output | 4 | Minutes units digit, BCD |
| min_tens | output | 4 | Minutes tens digit, BCD |
| hr_ones | output | 4 | Hours units digit, BCD |
| hr_tens | output | 4 | Hours tens digit, BCD |
| sec_carry | output | 1 | Seconds-to-minutes carry strobe |
| min_carry | output | 1 | Minutes-to-hours carry strobe |

## Verification
A corrupted digit register appears on the digit outputs in the very next cycle, because every digit is a port. A wrong carry decision shows at once on the strobe outputs. A missed or doubled step shows one tick later as a field that differs from the reference time. A wrong wrap value may stay hidden until the field reaches its last value, after up to 60 seconds, 60 minutes or 24 hours of ticks. For that reason the stimulus reaches every field boundary quickly, partly by using calibration to jump to the end of the day.

// File: rtl/tod_pkg.sv
// Shared digit type and limits for the time-of-day counter.
package tod_pkg;
    localparam int DIGIT_W = 4;
    typedef logic [DIGIT_W-1:0] bcd_t;
    localparam bcd_t BCD_NINE = 4'd9;
endpackage

// File: rtl/tod_bcd_field.sv
// Two-digit BCD field. The ones digit counts 0..9 and carries into the tens.
// The whole field returns to 00 when stepped at LAST_TENS/LAST_ONES.
// Assumes step is a single-cycle enable in the clk domain.
module tod_bcd_field #(
    parameter tod_pkg::bcd_t LAST_TENS = 4'd5,
    parameter tod_pkg::bcd_t LAST_ONES = 4'd9
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          step,
    output tod_pkg::bcd_t ones,
    output tod_pkg::bcd_t tens,
    output logic          at_last
);
    import tod_pkg::*;

    // Flags the terminal value of this field.
    always_comb at_last = (tens == LAST_TENS) && (ones == LAST_ONES);

    // Digit update: clear on reset, wrap at terminal value, else BCD increment.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ones <= '0;
            tens <= '0;
        end else if (step) begin
            if (at_last) begin
                ones <= '0;
                tens <= '0;
            end else if (ones == BCD_NINE) begin
                ones <= '0;
                tens <= tens + 1'b1;
            end else begin
                ones <= ones + 1'b1;
            end
        end
    end
endmodule

// File: rtl/tod_step_ctl.sv
// Step and carry steering between the three fields. A field under
// calibration steps on cal_tick, ignores its incoming carry and emits none.
// Purely combinational; assumes all enables are in the clk domain.
module tod_step_ctl (
    input  logic sec_tick,
    input  logic cal_tick,
    input  logic cal_min,
    input  logic cal_hr,
    input  logic sec_last,
    input  logic min_last,
    output logic sec_step,
    output logic min_step,
    output logic hr_step,
    output logic sec_carry,
    output logic min_carry
);
    // Carry strobes from the terminal state of each field.
    always_comb begin
        sec_carry = sec_tick & sec_last;
        min_carry = sec_carry & min_last & ~cal_min;
    end

    // Step source for each field: calibration rate or carry chain.
    always_comb begin
        sec_step = sec_tick;
        min_step = cal_min ? cal_tick : sec_carry;
        hr_step  = cal_hr  ? cal_tick : min_carry;
    end
endmodule

// File: rtl/tod_counter.sv
// 24-hour BCD time-of-day counter. It advances on a one-cycle second tick
// and has minutes and hours calibration that leaves the other fields running.
// Assumes calibration levels are clean and synchronous to clk.
module tod_counter (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sec_tick,
    input  logic       cal_tick,
    input  logic       cal_min,
    input  logic       cal_hr,
    output logic [3:0] sec_ones,
    output logic [3:0] sec_tens,
    output logic [3:0] min_ones,
    output logic [3:0] min_tens,
    output logic [3:0] hr_ones,
    output logic [3:0] hr_tens,
    output logic       sec_carry,
    output logic       min_carry
);
    logic sec_step, min_step, hr_step;
    logic sec_last, min_last, hr_last;

    tod_step_ctl u_ctl (
        .sec_tick (sec_tick),
        .cal_tick (cal_tick),
        .cal_min  (cal_min),
        .cal_hr   (cal_hr),
        .sec_last (sec_last),
        .min_last (min_last),
        .sec_step (sec_step),
        .min_step (min_step),
        .hr_step  (hr_step),
        .sec_carry(sec_carry),
        .min_carry(min_carry)
    );

    tod_bcd_field #(.LAST_TENS(4'd5), .LAST_ONES(4'd9)) u_sec (
        .clk(clk), .rst_n(rst_n), .step(sec_step),
        .ones(sec_ones), .tens(sec_tens), .at_last(sec_last)
    );

    tod_bcd_field #(.LAST_TENS(4'd5), .LAST_ONES(4'd9)) u_min (
        .clk(clk), .rst_n(rst_n), .step(min_step),
        .ones(min_ones), .tens(min_tens), .at_last(min_last)
    );

    tod_bcd_field #(.LAST_TENS(4'd2), .LAST_ONES(4'd3)) u_hr (
        .clk(clk), .rst_n(rst_n), .step(hr_step),
        .ones(hr_ones), .tens(hr_tens), .at_last(hr_last)
    );
endmodule

// File: rtl/tod_counter_chk.sv
// Port-level property checker for tod_counter, attached by bind.
module tod_counter_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       sec_tick,
    input logic       cal_tick,
    input logic       cal_min,
    input logic       cal_hr,
    input logic [3:0] sec_ones,
    input logic [3:0] sec_tens,
    input logic [3:0] min_ones,
    input logic [3:0] min_tens,
    input logic [3:0] hr_ones,
    input logic [3:0] hr_tens,
    input logic       sec_carry,
    input logic       min_carry
);
    p_reset_clear_r1: assert property (@(posedge clk)
        !rst_n |=> ({sec_ones, sec_tens, min_ones, min_tens, hr_ones, hr_tens} == '0));

    p_sec_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (sec_ones <= 4'd9) && (sec_tens <= 4'd5));

    p_sec_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !sec_tick |=> $stable({sec_tens, sec_ones}));

    p_sec_wrap_r3: assert property (@(posedge clk) disable iff (!rst_n)
        sec_carry |=> (sec_ones == 4'd0) && (sec_tens == 4'd0));

    p_min_wrap_r4: assert property (@(posedge clk) disable iff (!rst_n)
        min_carry |=> (min_ones == 4'd0) && (min_tens == 4'd0));

    p_min_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!cal_min && !sec_carry) |=> $stable({min_tens, min_ones}));

    p_hr_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (hr_tens <= 4'd2) && ((hr_tens != 4'd2) || (hr_ones <= 4'd3)));

    p_cal_min_no_carry_r6: assert property (@(posedge clk) disable iff (!rst_n)
        cal_min |-> !min_carry);

    p_cal_hr_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (cal_hr && !cal_tick) |=> $stable({hr_tens, hr_ones}));

    p_idle_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!cal_min && !cal_hr && !sec_tick)
        |=> $stable({sec_ones, sec_tens, min_ones, min_tens, hr_ones, hr_tens}));
endmodule

bind tod_counter tod_counter_chk u_chk (
    .clk(clk), .rst_n(rst_n), .sec_tick(sec_tick), .cal_tick(cal_tick),
    .cal_min(cal_min), .cal_hr(cal_hr),
    .sec_ones(sec_ones), .sec_tens(sec_tens), .min_ones(min_ones),
    .min_tens(min_tens), .hr_ones(hr_ones), .hr_tens(hr_tens),
    .sec_carry(sec_carry), .min_carry(min_carry)
);

// File: tb/tod_counter_tb.sv
`timescale 1ns/1ps
// Bench for tod_counter: a behavioural integer time model, compared every clock.
module tod_counter_tb;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sec_tick = 1'b0, cal_tick = 1'b0, cal_min = 1'b0, cal_hr = 1'b0;
    logic [3:0] sec_ones, sec_tens, min_ones, min_tens, hr_ones, hr_tens;
    logic sec_carry, min_carry;

    int vectors = 0;
    int fails = 0;
    int ms = 0, mm = 0, mh = 0;   // model seconds, minutes, hours
    bit done = 1'b0;

    always #4 clk = ~clk;   // 125 MHz

    tod_counter u_dut (
        .clk(clk), .rst_n(rst_n), .sec_tick(sec_tick), .cal_tick(cal_tick),
        .cal_min(cal_min), .cal_hr(cal_hr),
        .sec_ones(sec_ones), .sec_tens(sec_tens), .min_ones(min_ones),
        .min_tens(min_tens), .hr_ones(hr_ones), .hr_tens(hr_tens),
        .sec_carry(sec_carry), .min_carry(min_carry)
    );

    function automatic int bcd2(input logic [3:0] t, input logic [3:0] o);
        if (t > 9 || o > 9) return -1;
        return t * 10 + o;
    endfunction

    task automatic chk(input string req, input string phase, input int act, input int exp);
        vectors++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s [%s] actual=%0d expected=%0d", req, phase, act, exp);
        end
    endtask

    // One cycle: drive at negedge, compare, advance model to the next edge.
    task automatic cycle(input bit rn, input bit st, input bit ct,
                         input bit cm, input bit ch, input string phase);
        bit esc, emc;
        @(negedge clk);
        rst_n = rn; sec_tick = st; cal_tick = ct; cal_min = cm; cal_hr = ch;
        #1;
        esc = rn && st && (ms == 59);
        emc = esc && (mm == 59) && !cm;
        chk("R2 seconds", phase, bcd2(sec_tens, sec_ones), ms);
        chk("R4 minutes", phase, bcd2(min_tens, min_ones), mm);
        chk("R5 hours",   phase, bcd2(hr_tens, hr_ones), mh);
        chk("R3 sec_carry", phase, int'(sec_carry), int'(esc));
        chk("R4 min_carry", phase, int'(min_carry), int'(emc));
        if (!rn) begin
            ms = 0; mm = 0; mh = 0;
        end else begin
            if (st) ms = (ms + 1) % 60;
            if (cm ? ct : esc) mm = (mm + 1) % 60;
            if (ch ? ct : emc) mh = (mh + 1) % 24;
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        // R1: reset from power-up; the model starts at zero
        for (int i = 0; i < 3; i++) cycle(0, 0, 0, 0, 0, "R1 reset");
        // R2/R3: sparse second ticks
        for (int i = 0; i < 240; i++) cycle(1, (i % 3) == 0, 0, 0, 0, "R2 sparse");
        // R3/R4/R5: dense ticks across minute and hour rollovers
        for (int i = 0; i < 7400; i++) cycle(1, 1, 0, 0, 0, "R5 dense");
        // R6: minute calibration while seconds run
        for (int i = 0; i < 400; i++) cycle(1, 1, (i % 4) == 0, 1, 0, "R6 cal_min");
        // R7: hour calibration while seconds and minutes run
        for (int i = 0; i < 400; i++) cycle(1, 1, (i % 4) == 0, 0, 1, "R7 cal_hr");
        // R6/R7: both calibrations together
        for (int i = 0; i < 200; i++) cycle(1, i[0], (i % 3) == 0, 1, 1, "R6 R7 both");
        // R8: cal_tick alone has no effect
        for (int i = 0; i < 60; i++) cycle(1, 0, 1, 0, 0, "R8 idle cal_tick");
        // R9: calibrate to 23:59, then cross midnight
        while (mh != 23) cycle(1, 0, 1, 0, 1, "R9 set hours");
        while (mm != 59) cycle(1, 0, 1, 1, 0, "R9 set minutes");
        for (int i = 0; i < 150; i++) cycle(1, 1, 0, 0, 0, "R9 midnight");
        // R1: reset in mid-run
        cycle(0, 1, 1, 1, 1, "R1 mid reset");
        for (int i = 0; i < 5; i++) cycle(1, 1, 0, 0, 0, "R1 after reset");
        finish_run();
    end
endmodule